// File: doc/BRIEF.md
# Bus Line Monitor with Idle Detection

This block watches four open-drain lines: the two wires of an I2C-style bus (clock and data) and two side-band lines, a control input and an alert input. Each line passes through a two-flop synchronizer. The block then reports the line's level as a raw status bit. Edge flags are latched for the control line and the alert line. The control line's edge flag uses a polarity chosen by a configuration pin. The alert line's flag fires only when the line falls.

An idle timer declares the bus free once the clock and data lines have both stayed high for a programmed number of clock cycles. With the default parameter at a 100 MHz clock, that period is 50 microseconds. Firmware reads all seven bits from one status word. It clears the two edge flags by writing a one to the matching bit of the clear word. All pins are plain control and status pins, with no stream interface.

Top module: `bus_line_monitor`

## Requirements
- R1: After reset, status bits 3:0 read 1111, and bit 4 (control edge), bit 5 (alert edge) and bit 6 (bus free) read 0.
- R2: Status bits 0, 1, 2 and 3 show the levels of `scl_i`, `sda_i`, `ctl_i` and `alert_i`. Each bit reflects, after the third rising clock edge, the level sampled at the first of those edges.
- R3: With `ctl_rise_sel` = 1, a rising edge of `ctl_i` sets status bit 4 in the same cycle that raw bit 2 changes, and a falling edge leaves it unchanged.
- R4: With `ctl_rise_sel` = 0, a falling edge of `ctl_i` sets status bit 4, and a rising edge leaves it unchanged.
- R5: A falling edge of `alert_i` sets status bit 5 in the same cycle that raw bit 3 changes, and a rising edge leaves it unchanged.
- R6: The edge flags stay set until a clock edge with `clr_we` = 1. At that edge, `clr_data[0]` = 1 clears bit 4 and `clr_data[1]` = 1 clears bit 5. A zero in either position leaves that flag as it was.
- R7: If a qualifying edge and a clear of the same flag land on the same clock edge, the flag ends up set.
- R8: Status bit 6 rises exactly `IDLE_CYCLES` + 2 clock edges after the later of `scl_i` and `sda_i` goes high, provided both stay high throughout.
- R9: Status bit 6 drops in the same cycle that raw bit 0 or raw bit 1 drops. Any low, even a single cycle, restarts the idle count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| ctl_i | input | 1 | Control side-band line level |
| alert_i | input | 1 | Alert side-band line level |
| ctl_rise_sel | input | 1 | 1: control flag on rising edge; 0: on falling edge |
| clr_we | input | 1 | Clear-word write strobe |
| clr_data | input | 2 | Write-one-to-clear mask: bit 0 control flag, bit 1 alert flag |
| status_o | output | 7 | {bus_free, alert_edge, ctl_edge, alert_raw, ctl_raw, sda_raw, scl_raw} |

## Verification
The bench times the idle window to the exact edge on both sides. A timer that is off by one sets the bus-free flag one cycle early or late, and a design that does not restart the count lets a one-cycle glitch shorten the window. It lands a clear on the same edge as a fresh control edge. A design where the clear wins loses that event. It sends the opposite edge under each polarity setting, and an edge detector that ignores the polarity or fires on both edges sets a flag that must stay clear. It also clears one flag while the other is set, which exposes a mask that clears both flags.

// File: rtl/blm_pkg.sv
package blm_pkg;
  localparam int NLINES    = 4;
  localparam int L_SCL     = 0;
  localparam int L_SDA     = 1;
  localparam int L_CTL     = 2;
  localparam int L_ALERT   = 3;
  localparam int ST_CTLEDG = 4;
  localparam int ST_ALTEDG = 5;
  localparam int ST_FREE   = 6;
  localparam int ST_W      = 7;
endpackage

// File: rtl/blm_line_sync.sv
// Two-flop synchronizer plus one registered raw stage used for edge compare.
module blm_line_sync #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic sync_o,
  output logic raw_o
);
  logic meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= IDLE_LVL;
      sync_o <= IDLE_LVL;
      raw_o  <= IDLE_LVL;
    end else begin
      meta_q <= d_i;
      sync_o <= meta_q;
      raw_o  <= sync_o;
    end
  end
endmodule

// File: rtl/blm_edge_latch.sv
// Sticky edge flag; a qualifying edge outranks a simultaneous clear.
module blm_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cur_i,
  input  logic prev_i,
  input  logic rise_i,
  input  logic clr_i,
  output logic flag_o
);
  logic hit;

  always_comb begin
    if (rise_i) hit = cur_i & ~prev_i;
    else        hit = ~cur_i & prev_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (hit)    flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/blm_idle_timer.sv
// Counts consecutive cycles with both bus lines high; flags bus free at the limit.
module blm_idle_timer #(
  parameter int IDLE_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic free_o
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          both_hi;

  assign both_hi = scl_i & sda_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      free_o <= 1'b0;
    end else if (!both_hi) begin
      cnt_q  <= '0;
      free_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      free_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bus_line_monitor.sv
module bus_line_monitor
  import blm_pkg::*;
#(
  parameter int IDLE_CYCLES = 5000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic            ctl_i,
  input  logic            alert_i,
  input  logic            ctl_rise_sel,
  input  logic            clr_we,
  input  logic [1:0]      clr_data,
  output logic [ST_W-1:0] status_o
);
  logic [NLINES-1:0] lines, sync_v, raw_v;
  logic ctl_flag, alert_flag, bus_free;

  assign lines = {alert_i, ctl_i, sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    blm_line_sync #(.IDLE_LVL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (lines[g]),
      .sync_o(sync_v[g]),
      .raw_o (raw_v[g])
    );
  end

  blm_edge_latch u_ctl_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .cur_i (sync_v[L_CTL]),
    .prev_i(raw_v[L_CTL]),
    .rise_i(ctl_rise_sel),
    .clr_i (clr_we & clr_data[0]),
    .flag_o(ctl_flag)
  );

  blm_edge_latch u_alert_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .cur_i (sync_v[L_ALERT]),
    .prev_i(raw_v[L_ALERT]),
    .rise_i(1'b0),
    .clr_i (clr_we & clr_data[1]),
    .flag_o(alert_flag)
  );

  blm_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (sync_v[L_SCL]),
    .sda_i (sync_v[L_SDA]),
    .free_o(bus_free)
  );

  assign status_o = {bus_free, alert_flag, ctl_flag, raw_v};
endmodule

// File: rtl/bus_line_monitor_chk.sv
module bus_line_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_i,
  input logic       ctl_i,
  input logic       alert_i,
  input logic       ctl_rise_sel,
  input logic       clr_we,
  input logic [1:0] clr_data,
  input logic [6:0] status_o
);
  logic [1:0] age;
  logic [3:0] lines;
  assign lines = {alert_i, ctl_i, sda_i, scl_i};

  always_ff @(posedge clk) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R2
  raw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (status_o[3:0] == $past(lines, 3)));

  // R3 R4
  ctl_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $rose(status_o[4])) |->
      ($past(ctl_rise_sel) ? $rose(status_o[2]) : $fell(status_o[2])));

  // R5
  alert_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $rose(status_o[5])) |-> $fell(status_o[3]));

  // R6
  ctl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $fell(status_o[4])) |-> $past(clr_we && clr_data[0]));

  // R6
  alert_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $fell(status_o[5])) |-> $past(clr_we && clr_data[1]));

  // R9
  free_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_o[0] && status_o[1]) |-> !status_o[6]);
endmodule

bind bus_line_monitor bus_line_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .ctl_i(ctl_i),
  .alert_i(alert_i), .ctl_rise_sel(ctl_rise_sel), .clr_we(clr_we),
  .clr_data(clr_data), .status_o(status_o)
);

// File: tb/tb_bus_line_monitor.sv
`timescale 1ns/1ps
module tb_bus_line_monitor;
  localparam int IDLE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, ctl = 1'b1, alert = 1'b1;
  logic rise_sel = 1'b1;
  logic clr_we = 1'b0;
  logic [1:0] clr_data = 2'b00;
  logic [6:0] st;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_line_monitor #(.IDLE_CYCLES(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .ctl_i(ctl),
    .alert_i(alert), .ctl_rise_sel(rise_sel), .clr_we(clr_we),
    .clr_data(clr_data), .status_o(st)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic clear(logic [1:0] m);
    clr_we = 1'b1; clr_data = m;
    tick(1);
    clr_we = 1'b0; clr_data = 2'b00;
  endtask

  task automatic t_reset();
    tick(2);
    check("R1 reset status", st, 7'b0001111);
    rst_n = 1'b1;
    tick(1);
    check("R1 after release", st, 7'b0001111);
  endtask

  task automatic t_raw();
    scl = 1'b0; ctl = 1'b0;
    tick(2);
    check("R2 raw before latency", {3'b0, st[3:0]}, 7'b0001111);
    tick(1);
    check("R2 raw scl/ctl low", {3'b0, st[3:0]}, 7'b0001010);
    scl = 1'b1; ctl = 1'b1;
    tick(3);
    check("R2 raw back high", {3'b0, st[3:0]}, 7'b0001111);
    clear(2'b01);
  endtask

  task automatic t_ctl_rise();
    rise_sel = 1'b1;
    ctl = 1'b0; tick(4);
    check("R3 falling ignored", {6'b0, st[4]}, 7'd0);
    ctl = 1'b1; tick(2);
    check("R3 not yet", {6'b0, st[4]}, 7'd0);
    tick(1);
    check("R3 rising sets", {6'b0, st[4]}, 7'd1);
    clear(2'b01);
    check("R6 clear ctl", {6'b0, st[4]}, 7'd0);
  endtask

  task automatic t_ctl_fall();
    rise_sel = 1'b0;
    ctl = 1'b0; tick(3);
    check("R4 falling sets", {6'b0, st[4]}, 7'd1);
    clear(2'b01);
    ctl = 1'b1; tick(4);
    check("R4 rising ignored", {6'b0, st[4]}, 7'd0);
    rise_sel = 1'b1;
  endtask

  task automatic t_alert();
    alert = 1'b0; tick(2);
    check("R5 not yet", {6'b0, st[5]}, 7'd0);
    tick(1);
    check("R5 falling sets", {6'b0, st[5]}, 7'd1);
    tick(5);
    check("R6 sticky", {6'b0, st[5]}, 7'd1);
    clear(2'b01);
    check("R6 other flag kept", {6'b0, st[5]}, 7'd1);
    clr_we = 1'b1; clr_data = 2'b00; tick(1); clr_we = 1'b0;
    check("R6 zero mask no effect", {6'b0, st[5]}, 7'd1);
    clear(2'b10);
    check("R6 clear alert", {6'b0, st[5]}, 7'd0);
    alert = 1'b1; tick(4);
    check("R5 rising ignored", {6'b0, st[5]}, 7'd0);
  endtask

  task automatic t_collide();
    rise_sel = 1'b1;
    ctl = 1'b0; tick(4);
    ctl = 1'b1; tick(2);
    clear(2'b01);
    check("R7 edge beats clear", {6'b0, st[4]}, 7'd1);
    clear(2'b01);
    check("R7 later clear", {6'b0, st[4]}, 7'd0);
  endtask

  task automatic t_idle();
    tick(IDLE + 4);
    check("R8 free when idle", {6'b0, st[6]}, 7'd1);
    sda = 1'b0; tick(2);
    check("R9 free before drop", {6'b0, st[6]}, 7'd1);
    tick(1);
    check("R9 free drops with raw", {6'b0, st[6]}, 7'd0);
    sda = 1'b1; tick(IDLE + 1);
    check("R8 free one early", {6'b0, st[6]}, 7'd0);
    tick(1);
    check("R8 free exact", {6'b0, st[6]}, 7'd1);
    tick(IDLE + 4);
    scl = 1'b0; tick(IDLE - 4);
    scl = 1'b1; tick(IDLE - 4);
    scl = 1'b0; tick(1);
    scl = 1'b1; tick(IDLE + 1);
    check("R9 glitch restarts", {6'b0, st[6]}, 7'd0);
    tick(1);
    check("R9 free after restart", {6'b0, st[6]}, 7'd1);
  endtask

  initial begin
    t_reset();
    t_raw();
    t_ctl_rise();
    t_ctl_fall();
    t_alert();
    t_collide();
    t_idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule